// File: doc/BRIEF.md
# Sequential Multiply-Accumulate FIR Engine

This block computes a finite impulse response filter with a single 16x16 signed multiplier, walking the taps one cycle each. Each accepted input sample triggers one pass over the taps, from the oldest stored sample to the newest. A multiplicand register, a product register and a guarded accumulator form a three-stage chain. In each tap cycle a new sample enters the multiplicand register, the previous product is formed, and the product before that is summed.

The delay line is a small sample memory, separate from the coefficient store, so one sample read and one coefficient read happen in the same cycle. The delay line needs no separate shift pass: while a tap loads its sample, the same sample is written one slot further down the line. After the last tap, one more multiply cycle and one drain cycle finish the sum. The result is rounded toward minus infinity by a Q15 right shift, saturated to 16 bits, and presented with a one-cycle valid strobe and the output-buffer address it belongs to. The address advances after every result.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset `busy_o`, `result_valid_o`, `result_o` and `result_addr_o` are 0. Every stored sample and coefficient is 0, so the first result after reset depends only on the first accepted sample.
- R2: For each accepted sample, the result is sat16((sum over k=0..4 of h_k * x(n-k)) >>> 15). The shift is arithmetic. x(n) is the newest accepted sample, and x(n-k) is the sample accepted k acceptances earlier, or 0 if there was none since reset.
- R3: With `coef_we_i` high at a clock edge, `coef_data_i` is written as coefficient h_k, where k = `coef_addr_i`, and h_k multiplies x(n-k). A write made while idle applies to the next accepted sample.
- R4: A shifted sum above 32767 gives 32767 (0x7FFF). A shifted sum below -32768 gives -32768 (0x8000).
- R5: `sample_valid_i` is accepted only at an edge where `busy_o` is low. A sample presented while `busy_o` is high has no effect on any later result.
- R6: `busy_o` is high for exactly NUM_TAPS+2 (7) cycles, starting in the cycle after the accepting edge. The result appears with `result_valid_o` in the first cycle after that, when `busy_o` is low again.
- R7: `result_valid_o` is high for exactly one cycle per accepted sample.
- R8: `result_addr_o` carries the buffer address of the current result. It is 0 for the first result, is one higher for each following result, wraps modulo 16, and changes only when a new result is presented.
- R9: Taps are walked oldest first, and the delay line shifts by one slot per accepted sample. An impulse of 32767 followed by zeros therefore produces results proportional to h0, h1, h2, h3, h4 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 16 | Signed input sample |
| sample_valid_i | input | 1 | Sample strobe, taken only while idle |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_addr_i | input | 3 | Coefficient index k |
| coef_data_i | input | 16 | Signed Q15 coefficient |
| busy_o | output | 1 | Tap sequence in progress |
| result_o | output | 16 | Saturated Q15 filter output |
| result_valid_o | output | 1 | One-cycle result strobe |
| result_addr_o | output | 4 | Output-buffer address of this result |

## Verification
- **Impulse followed by zeros:** reveals the tap-to-coefficient pairing and whether the delay line shifts, because each later result must equal the next coefficient.
- **Pseudo-random samples against mixed-sign coefficients:** expose errors in accumulator alignment, sign extension and the treatment of the first and last product in the chain.
- **Full-scale runs of one sign:** drive both saturation rails.
- **Injected sample while busy, and reloaded coefficients:** show that a busy-time sample leaves the history untouched and that new coefficients apply from the next pass.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TAP   = 2'd1,
    ST_MUL   = 2'd2,
    ST_DRAIN = 2'd3
  } fir_state_e;
endpackage

// File: rtl/fir_regfile.sv
module fir_regfile #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[i] <= '0;
      else if (we_i && (waddr_i == AW'(i)))    mem_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int j = 0; j < DEPTH; j++)
      if (raddr_i == AW'(j)) rdata_o = mem_q[j];
  end
endmodule

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_pkg::*;
#(
  parameter int unsigned NUM_TAPS = 5,
  localparam int unsigned AW = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_valid_i,
  output logic          busy_o,
  output logic          accept_o,
  output logic          step_o,
  output logic          first_o,
  output logic          shift_o,
  output logic          mul_o,
  output logic          drain_o,
  output logic [AW-1:0] tap_idx_o
);
  localparam logic [AW-1:0] LAST = AW'(NUM_TAPS - 1);

  fir_state_e state_q;
  logic [AW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (sample_valid_i) begin
          state_q <= ST_TAP;
          idx_q   <= LAST;
        end
        ST_TAP: begin
          if (idx_q == '0) state_q <= ST_MUL;
          else             idx_q   <= idx_q - AW'(1);
        end
        ST_MUL:   state_q <= ST_DRAIN;
        ST_DRAIN: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign accept_o  = (state_q == ST_IDLE) && sample_valid_i;
  assign step_o    = (state_q == ST_TAP);
  assign first_o   = step_o && (idx_q == LAST);
  assign shift_o   = step_o && (idx_q != LAST);
  assign mul_o     = (state_q == ST_MUL);
  assign drain_o   = (state_q == ST_DRAIN);
  assign tap_idx_o = idx_q;

  AST_BUSY_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(sample_valid_i)); // R5
endmodule

// File: rtl/fir_mac_dp.sv
module fir_mac_dp #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned GUARD_W    = 3,
  parameter int unsigned FRAC_SHIFT = 15,
  parameter int unsigned OBUF_AW    = 4,
  localparam int unsigned PROD_W = 2 * DATA_W,
  localparam int unsigned ACC_W  = PROD_W + GUARD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               first_i,
  input  logic               mul_i,
  input  logic               drain_i,
  input  logic [DATA_W-1:0]  x_i,
  input  logic [DATA_W-1:0]  h_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               result_valid_o,
  output logic [OBUF_AW-1:0] result_addr_o
);
  logic signed [DATA_W-1:0] t_q, c_q;
  logic signed [PROD_W-1:0] p_q, prod;
  logic signed [ACC_W-1:0]  acc_q, acc_sum, acc_shr;
  logic [OBUF_AW-1:0]       wptr_q;
  logic                     ovf;
  logic [DATA_W-1:0]        sat_val;

  assign prod    = PROD_W'(t_q) * PROD_W'(c_q);
  assign acc_sum = acc_q + ACC_W'(p_q);
  assign acc_shr = acc_sum >>> FRAC_SHIFT;
  // overflow when the bits above the output sign are not a pure sign extension
  assign ovf     = !(&acc_shr[ACC_W-1:DATA_W-1]) && (|acc_shr[ACC_W-1:DATA_W-1]);
  assign sat_val = !ovf ? acc_shr[DATA_W-1:0] :
                   acc_shr[ACC_W-1] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q <= '0;
      c_q <= '0;
      p_q <= '0;
      acc_q <= '0;
    end else if (step_i) begin
      t_q <= x_i;
      c_q <= h_i;
      if (first_i) begin
        p_q   <= '0;
        acc_q <= '0;
      end else begin
        p_q   <= prod;
        acc_q <= acc_sum;
      end
    end else if (mul_i) begin
      p_q   <= prod;
      acc_q <= acc_sum;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o       <= '0;
      result_valid_o <= 1'b0;
      result_addr_o  <= '0;
      wptr_q         <= '0;
    end else begin
      result_valid_o <= drain_i;
      if (drain_i) begin
        result_o      <= sat_val;
        result_addr_o <= wptr_q;
        wptr_q        <= wptr_q + OBUF_AW'(1);
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o); // R7
  AST_ADDR_ON_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_addr_o) |-> result_valid_o); // R8
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_addr_o) |-> (result_addr_o == $past(result_addr_o) + 1'b1)); // R8
  AST_VALID_AFTER_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_i |=> result_valid_o); // R6
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine #(
  parameter int unsigned NUM_TAPS   = 5,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned GUARD_W    = 3,
  parameter int unsigned FRAC_SHIFT = 15,
  parameter int unsigned OBUF_AW    = 4
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic [DATA_W-1:0]                             sample_i,
  input  logic                                          sample_valid_i,
  input  logic                                          coef_we_i,
  input  logic [((NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1)-1:0] coef_addr_i,
  input  logic [DATA_W-1:0]                             coef_data_i,
  output logic                                          busy_o,
  output logic [DATA_W-1:0]                             result_o,
  output logic                                          result_valid_o,
  output logic [OBUF_AW-1:0]                            result_addr_o
);
  localparam int unsigned AW = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1;

  logic accept, step, first, shift, mul, drain;
  logic [AW-1:0] tap_idx;
  logic [DATA_W-1:0] x_rd, h_rd, ram_wdata;
  logic [AW-1:0] ram_waddr;
  logic ram_we;

  fir_ctrl #(.NUM_TAPS(NUM_TAPS)) u_ctrl (
    .clk_i, .rst_ni, .sample_valid_i,
    .busy_o, .accept_o(accept), .step_o(step), .first_o(first),
    .shift_o(shift), .mul_o(mul), .drain_o(drain), .tap_idx_o(tap_idx)
  );

  // new sample lands in slot 0; during a tap the read sample moves one slot older
  assign ram_we    = accept || shift;
  assign ram_waddr = accept ? '0 : tap_idx + AW'(1);
  assign ram_wdata = accept ? sample_i : x_rd;

  fir_regfile #(.DEPTH(NUM_TAPS), .WIDTH(DATA_W)) u_samples (
    .clk_i, .rst_ni, .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(ram_wdata),
    .raddr_i(tap_idx), .rdata_o(x_rd)
  );

  fir_regfile #(.DEPTH(NUM_TAPS), .WIDTH(DATA_W)) u_coefs (
    .clk_i, .rst_ni, .we_i(coef_we_i), .waddr_i(coef_addr_i), .wdata_i(coef_data_i),
    .raddr_i(tap_idx), .rdata_o(h_rd)
  );

  fir_mac_dp #(
    .DATA_W(DATA_W), .GUARD_W(GUARD_W), .FRAC_SHIFT(FRAC_SHIFT), .OBUF_AW(OBUF_AW)
  ) u_dp (
    .clk_i, .rst_ni, .step_i(step), .first_i(first), .mul_i(mul), .drain_i(drain),
    .x_i(x_rd), .h_i(h_rd), .result_o, .result_valid_o, .result_addr_o
  );

  AST_RESULT_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> (!busy_o && $past(busy_o))); // R6
endmodule

// File: tb/tb_fir_mac_engine.sv
module tb_fir_mac_engine;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] sample = '0;
  logic sample_valid = 1'b0;
  logic coef_we = 1'b0;
  logic [2:0] coef_addr = '0;
  logic [15:0] coef_data = '0;
  logic busy, result_valid;
  logic [15:0] result;
  logic [3:0] result_addr;

  always #2 clk = ~clk;

  fir_mac_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sample_valid_i(sample_valid),
    .coef_we_i(coef_we), .coef_addr_i(coef_addr), .coef_data_i(coef_data),
    .busy_o(busy), .result_o(result), .result_valid_o(result_valid),
    .result_addr_o(result_addr)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int hist [N];
  int coef [N];
  int exp_addr = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model();
    longint s = 0;
    longint sh;
    for (int k = 0; k < N; k++) s += longint'(coef[k]) * longint'(hist[k]);
    sh = s >>> 15;
    if (sh > 32767) return 32767;
    if (sh < -32768) return -32768;
    return int'(sh);
  endfunction

  task automatic load_coefs(input int c0, c1, c2, c3, c4);
    int v [N];
    v[0] = c0; v[1] = c1; v[2] = c2; v[3] = c3; v[4] = c4;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      coef_we = 1'b1; coef_addr = 3'(k); coef_data = 16'(v[k]);
      coef[k] = v[k];
    end
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  // one accepted sample; optional junk strobe during busy
  task automatic run_sample(input int x, input string req, input bit inject);
    int cnt = 0;
    bit busy_ok = 1;
    int exp;
    for (int k = N - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    exp = model();
    @(negedge clk);
    sample_valid = 1'b1; sample = 16'(x);
    @(negedge clk);
    sample_valid = 1'b0;
    if (!busy) busy_ok = 0;
    while (!result_valid && cnt < 40) begin
      if (inject && cnt == 2) begin sample_valid = 1'b1; sample = 16'sd12345; end
      if (inject && cnt == 3) sample_valid = 1'b0;
      @(negedge clk);
      cnt++;
      if (!result_valid && !busy) busy_ok = 0;
    end
    sample_valid = 1'b0;
    check(busy_ok, "R6 busy through sequence", int'(busy), 1);
    check(cnt == N + 2, "R6 latency", cnt, N + 2);
    check(!busy, "R6 busy low at result", int'(busy), 0);
    check($signed(result) == exp, req, int'($signed(result)), exp);
    check(int'(result_addr) == exp_addr, "R8 address", int'(result_addr), exp_addr);
    exp_addr = (exp_addr + 1) % 16;
    @(negedge clk);
    check(!result_valid, "R7 single-cycle valid", int'(result_valid), 0);
  endtask

  task automatic t_reset;
    check(!busy, "R1 busy reset", int'(busy), 0);
    check(!result_valid, "R1 valid reset", int'(result_valid), 0);
    check(result == 0, "R1 result reset", int'(result), 0);
    check(result_addr == 0, "R1 address reset", int'(result_addr), 0);
  endtask

  task automatic t_impulse;
    load_coefs(1000, -2000, 3000, -4000, 5000);
    run_sample(32767, "R1 first result uses only x(n)", 0);
    for (int k = 1; k < N; k++) run_sample(0, "R9 impulse order", 0);
    run_sample(0, "R9 impulse flushed", 0);
  endtask

  task automatic t_pattern;
    load_coefs(8192, -16384, 12000, 3000, -7000);
    for (int i = 0; i < 8; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_sample(int'($signed(lfsr)) / 2, "R2 pseudo-random pattern", 0);
    end
  endtask

  task automatic t_saturation;
    load_coefs(32767, 32767, 32767, 32767, 32767);
    for (int i = 0; i < N; i++) run_sample(32767, "R4 positive saturation", 0);
    for (int i = 0; i < N; i++) run_sample(-32768, "R4 negative saturation", 0);
  endtask

  task automatic t_busy_ignore;
    load_coefs(4096, 8192, -4096, 2048, 1024);
    run_sample(3000, "R5 result with busy-time strobe", 1);
    run_sample(-5000, "R5 busy-time sample left no trace", 0);
  endtask

  task automatic t_coef_reload;
    load_coefs(-32768, 0, 0, 0, 16384);
    run_sample(1234, "R3 reloaded coefficients", 0);
    run_sample(-777, "R3 reloaded coefficients", 0);
    run_sample(20000, "R3 reloaded coefficients", 0);
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin hist[k] = 0; coef[k] = 0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_impulse();
    t_pattern();
    t_saturation();
    t_busy_ignore();
    t_coef_reload();
    check(exp_addr != 0 && n_chk > 100, "R8 wrapped past 15", exp_addr, 1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule